// File: doc/BRIEF.md
# Sample-Interval Pacer with Convert-Start Trigger

This block paces a data-acquisition run. A host programs an interval count, starts the timer and picks an input channel. While running, a 16-bit down counter moves one step on each pulse of a 1 MHz timebase enable. When the counter runs out it sends a one-clock pulse on `timer_out` and reloads itself from the programmed value. It keeps doing this until the host writes new settings.

Two sources can start a conversion: the rising edge of the timer output, and a low-to-high transition on the external convert pin, which is named active-low. Either edge yields a convert-start strobe one system clock wide. The external pin is resynchronised before its edge is detected. A channel register drives the multiplexer select and holds its value for the whole run, because in single-channel mode every conversion reads the same input.

Top module: `samp_pacer`

## Requirements
- R1: After reset `timer_out` and `conv_start` are low, `chan_sel` is 0 and the timer does not run. No `timer_out` pulse appears until the run bit is written to 1.
- R2: The host writes through `wr_en`/`wr_addr`/`wr_data`. Address 0 holds the interval count (16 bits). Address 1 is control, with bit 0 as the run bit. Address 2 holds the channel, in the low `CH_W` bits. A write takes effect on the clock edge that accepts it.
- R3: While running with programmed count N, `timer_out` pulses high for one clock once every N pulses of `tick_1us`. The counter then reloads by itself and keeps running.
- R4: A programmed count of 0 or 1 behaves as a count of 2.
- R5: A count written while the timer runs does not shorten or stretch the interval in progress. It takes effect from the next reload.
- R6: Writing 0 to the run bit stops the timer. No `timer_out` pulse and no timer-driven `conv_start` follow the edge that accepts that write.
- R7: Each rising edge of the timer output gives exactly one `conv_start` strobe, one clock wide, one clock after `timer_out` goes high.
- R8: A low-to-high transition on `ext_conv_n` passes a two-flop synchroniser. `conv_start` goes high for one clock on the third clock edge after the pin is first sampled high. A high-to-low transition gives no strobe.
- R9: When a timer edge and an external edge are detected in the same clock, they merge into one strobe that is one clock wide.
- R10: `chan_sel` changes only on a write to address 2. It holds its value while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-clock enable at the 1 MHz timebase rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register address |
| wr_data | input | CNT_W | Host write data |
| ext_conv_n | input | 1 | External convert pin; its rising edge starts a conversion |
| chan_sel | output | CH_W | Held multiplexer channel |
| timer_out | output | 1 | One-clock pulse at each interval end |
| conv_start | output | 1 | One-clock convert-start strobe |

## Verification
The two functions that can land in the same clock are the timer's interval-end edge and the resynchronised external convert edge. The bench predicts when the next timer pulse will occur from the measured interval. It raises the external pin exactly two clocks before that pulse, so both edge detectors fire in the same cycle. The scoreboard expects a single strobe at the predicted cycle, and the bench counts the strobes around that point to confirm that only one appeared.

// File: rtl/samp_pacer_pkg.sv
package samp_pacer_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CHAN  = 2'd2;
    localparam int RUN_BIT = 0;
    localparam int MIN_INTERVAL = 2;
endpackage

// File: rtl/pacer_regs.sv
module pacer_regs
    import samp_pacer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CH_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              run,
    output logic              halt,
    output logic [CH_W-1:0]   chan
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic [CH_W-1:0]  chan;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_count, wr_ctrl, wr_chan;

    always_comb begin
        wr_count = wr_en && (wr_addr == ADR_COUNT);
        wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
        wr_chan  = wr_en && (wr_addr == ADR_CHAN);
        r_d = r_q;
        if (wr_count) r_d.count = wr_data;
        if (wr_ctrl)  r_d.run   = wr_data[RUN_BIT];
        if (wr_chan)  r_d.chan  = wr_data[CH_W-1:0];
        halt = wr_ctrl && !wr_data[RUN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count = r_q.count;
    assign run   = r_q.run;
    assign chan  = r_q.chan;

    // R10: the channel only moves on a write to its address
    a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_chan |=> $stable(r_q.chan));
    // R6: a stop write clears the run state on the accepting edge
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !r_q.run);
endmodule

// File: rtl/pacer_interval.sv
module pacer_interval
    import samp_pacer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             halt,
    input  logic [CNT_W-1:0] count,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_INTERVAL);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             pulse;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] reload;
    logic             expire;

    always_comb begin
        reload = (count < FLOOR) ? FLOOR : count;
        expire = 1'b0;
        t_d = t_q;
        t_d.pulse = 1'b0;
        if (!run || halt) begin
            t_d.active = 1'b0;
            t_d.cnt    = '0;
        end else if (!t_q.active) begin
            t_d.active = 1'b1;
            t_d.cnt    = reload;
        end else if (tick) begin
            if (t_q.cnt == ONE) begin
                expire    = 1'b1;
                t_d.pulse = 1'b1;
                t_d.cnt   = reload;
            end else begin
                t_d.cnt = t_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pulse = t_q.pulse;

    // R3: an interval-end pulse is one clock wide
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.pulse |=> !t_q.pulse);
    // R4: the value reloaded with a pulse is never below the floor
    a_r4_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.pulse |-> (t_q.cnt >= FLOOR));
    // R6: a stopped or stopping timer issues no pulse
    a_r6_no_pulse_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || halt) |=> !t_q.pulse);
    // R1/R3: a pulse only ever follows an active count
    a_r3_pulse_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> t_q.active);
endmodule

// File: rtl/pacer_extsync.sv
module pacer_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh = {s_q.sh[STAGES-1:0], pin};
        rise = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // R8: one detected edge lasts exactly one clock
    a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/samp_pacer.sv
module samp_pacer
    import samp_pacer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int CH_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_conv_n,
    output logic [CH_W-1:0]   chan_sel,
    output logic              timer_out,
    output logic              conv_start
);
    typedef struct packed {
        logic tmr_prev;
        logic conv;
    } top_t;

    top_t p_d, p_q;
    logic [CNT_W-1:0] count;
    logic run, halt, tmr_pulse, ext_rise, tmr_rise;

    pacer_regs #(.CNT_W(CNT_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .run(run), .halt(halt), .chan(chan_sel)
    );

    pacer_interval #(.CNT_W(CNT_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .run(run), .halt(halt),
        .count(count), .pulse(tmr_pulse)
    );

    pacer_extsync #(.STAGES(SYNC_STAGES)) u_extsync (
        .clk(clk), .rst_n(rst_n), .pin(ext_conv_n), .rise(ext_rise)
    );

    always_comb begin
        tmr_rise = tmr_pulse & ~p_q.tmr_prev;
        p_d.tmr_prev = tmr_pulse;
        p_d.conv     = tmr_rise | ext_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign timer_out  = tmr_pulse;
    assign conv_start = p_q.conv;

    // R7: every timer edge yields a strobe one clock later
    a_r7_timer_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rise |=> conv_start);
    // R8/R9: a strobe always stems from a detected edge
    a_r9_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(tmr_rise || ext_rise));
    // R9: coincident edges give one strobe that then ends
    a_r9_merge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_rise && ext_rise) |=> (conv_start ##1 !conv_start));
endmodule

// File: tb/tb_samp_pacer.sv
`timescale 1ns/1ps
module tb_samp_pacer;
    localparam int CNT_W = 16;
    localparam int CH_W  = 4;
    localparam int TDIV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1us = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic ext_conv_n = 1'b1;
    logic [CH_W-1:0] chan_sel;
    logic timer_out, conv_start;

    samp_pacer #(.CNT_W(CNT_W), .CH_W(CH_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ext_conv_n(ext_conv_n),
        .chan_sel(chan_sel), .timer_out(timer_out), .conv_start(conv_start)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int tcount = 0, tlast = 0, tprev = 0, ccount = 0;
    int exp_q[$];
    bit done = 1'b0;
    int tdiv_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
        tick_1us <= (tdiv_cnt == TDIV-1);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (timer_out) begin
                tprev = tlast;
                tlast = cyc;
                tcount++;
                exp_q.push_back(cyc + 1);
            end
            if (conv_start) begin
                int idx = -1;
                ccount++;
                foreach (exp_q[i]) if (exp_q[i] == cyc && idx < 0) idx = i;
                check(idx >= 0, "R7/R8 strobe cycle", cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                if (idx >= 0) exp_q.delete(idx);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_tpulse();
        int c = tcount;
        while (tcount == c) step(1);
    endtask

    task automatic ext_edge(input bit merged);
        ext_conv_n = 1'b1;
        if (!merged) exp_q.push_back(cyc + 3);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int c0, t0, tsync;
        step(3);
        // R1: reset state
        check(timer_out == 1'b0, "R1 timer_out", timer_out, 0);
        check(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
        check(chan_sel == 0, "R1 chan_sel", chan_sel, 0);
        rst_n = 1'b1;
        step(40);
        check(tcount == 0, "R1 idle timer pulses", tcount, 0);

        // R2 / R10: channel write
        host_wr(2'd2, 16'd5);
        check(chan_sel == 4'd5, "R2 chan write", chan_sel, 5);

        // R3: periodic pulses
        host_wr(2'd0, 16'd5);
        host_wr(2'd1, 16'd1);
        wait_tpulse();
        wait_tpulse();
        check(tlast - tprev == 5*TDIV, "R3 period N=5", tlast - tprev, 5*TDIV);
        wait_tpulse();
        check(tlast - tprev == 5*TDIV, "R3 auto reload", tlast - tprev, 5*TDIV);
        check(chan_sel == 4'd5, "R10 chan held in run", chan_sel, 5);

        // R5: new count mid-interval
        step(5);
        host_wr(2'd0, 16'd3);
        wait_tpulse();
        check(tlast - tprev == 5*TDIV, "R5 old interval finishes", tlast - tprev, 5*TDIV);
        wait_tpulse();
        check(tlast - tprev == 3*TDIV, "R5 new interval", tlast - tprev, 3*TDIV);

        // R4: counts 0 and 1 clamp to 2
        host_wr(2'd0, 16'd0);
        wait_tpulse();
        wait_tpulse();
        check(tlast - tprev == 2*TDIV, "R4 count 0", tlast - tprev, 2*TDIV);
        host_wr(2'd0, 16'd1);
        wait_tpulse();
        wait_tpulse();
        check(tlast - tprev == 2*TDIV, "R4 count 1", tlast - tprev, 2*TDIV);

        // R9: merge timer and external edges
        ext_conv_n = 1'b0;
        host_wr(2'd0, 16'd5);
        wait_tpulse();
        wait_tpulse();
        wait_tpulse();
        check(tlast - tprev == 5*TDIV, "R9 setup period", tlast - tprev, 5*TDIV);
        tsync = tlast;
        step(tsync + 5*TDIV - 2 - cyc);
        c0 = ccount;
        ext_edge(1'b1);
        step(6);
        check(ccount - c0 == 1, "R9 merged strobe count", ccount - c0, 1);
        check(tlast == tsync + 5*TDIV, "R9 timer pulse at merge", tlast, tsync + 5*TDIV);

        // R6: stop
        host_wr(2'd1, 16'd0);
        t0 = tcount;
        c0 = ccount;
        step(200);
        check(tcount == t0, "R6 no pulses after stop", tcount - t0, 0);
        check(ccount == c0, "R6 no strobes after stop", ccount - c0, 0);

        // R8: external edges with timer stopped
        ext_conv_n = 1'b0;
        step(6);
        c0 = ccount;
        ext_edge(1'b0);
        step(6);
        check(ccount - c0 == 1, "R8 rising edge strobe", ccount - c0, 1);
        c0 = ccount;
        ext_conv_n = 1'b0;
        step(8);
        check(ccount == c0, "R8 falling edge ignored", ccount - c0, 0);

        // R10: channel rewrite
        host_wr(2'd2, 16'd12);
        check(chan_sel == 4'd12, "R10 chan rewrite", chan_sel, 12);

        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule